// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block watches the fetch side of a processor's instruction bus with a bank of address comparators. It walks a small armed state machine toward a terminal state. Each comparator is set either to act at once when its address is fetched, or to mark the fetched opcode with a tag. A tagged opcode counts only if it later reaches execution. Tags belong to pipe entries that a flush can discard.

Software first fills the comparator, mode and next-state registers and then sets the arm bit. After that the program runs normally while the sequencer observes. Several sources can force the terminal state without any comparator match: two external tag lines, a software breakpoint request and a self-clearing trigger bit. On entry to the terminal state the block emits a one-cycle trace-start pulse and/or a one-cycle breakpoint pulse, as configured. It then stays in that state until it is disarmed.

Top module: `dbg_trig_seq`

## Requirements
- R1: After reset the state is DISARMED (0) and `trace_start` and `brk` are low.
- R2: Writing the control register (address 0) with bit 0 (arm) set moves a DISARMED sequencer to STATE1 (1) at that edge. A control write with bit 0 clear returns the sequencer to DISARMED from any state, including FINAL (4).
- R3: A comparator c is enabled by mode-register (address NCMP+1) bit NCMP+c, and its tag-mode bit c is clear. A valid fetch of its address (registers 1..NCMP) in state s (1..3) moves the state, at that edge, to field c (bits 3c+2:3c) of the next-state register at address NCMP+1+s.
- R4: When the tag-mode bit of comparator c is set, a matching fetch moves nothing and tags that opcode instead. The most recent fetch sits in slot 0, and each later fetch shifts it one slot up. An execute strobe that names the tagged slot causes the transition of R3 at that edge and consumes the tag.
- R5: A pipe flush clears every pending tag, so a later execute of any slot causes no transition.
- R6: When several comparator events occur in one cycle, the lowest-numbered comparator decides. A next-state field of 0 or 5..7 means the state does not move.
- R7: In states 1..3, either external tag line or the software breakpoint request moves the state to FINAL at that edge, and this wins over any comparator event. In DISARMED these inputs are ignored.
- R8: A control write with bit 0 and bit 1 (trigger) set moves the state to FINAL. Bit 1 has no effect when bit 0 is clear.
- R9: On entry to FINAL, `trace_start` is high for exactly one cycle if control bit 2 is set, and `brk` is high for exactly one cycle if control bit 3 is set. The enables take effect in the same cycle as the control write that loads them.
- R10: Once in FINAL, neither comparator events nor forced triggers change the state, and no further pulses occur until it is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_addr | input | ADDR_W | Address of the opcode being fetched |
| fetch_valid | input | 1 | An opcode enters the pipe this cycle |
| exec_valid | input | 1 | An opcode reaches execution this cycle |
| exec_slot | input | SLOT_W | Pipe slot of the executing opcode |
| pipe_flush | input | 1 | Pipe discarded; pending tags dropped |
| ext_tag_hi | input | 1 | External forced trigger, line A |
| ext_tag_lo | input | 1 | External forced trigger, line B |
| sw_brk_req | input | 1 | Software breakpoint request from coprocessor |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADR_W | Register address |
| cfg_wdata | input | DATA_W | Register write data |
| state | output | 3 | Current sequencer state |
| trace_start | output | 1 | One-cycle trace start pulse |
| brk | output | 1 | One-cycle breakpoint pulse |

## Verification
The assertions assume that `exec_slot` always names a slot below TAG_DEPTH. They also assume that the caller never writes a control word that sets the trigger bit during a flush that it expects to discard. The assertions also take for granted that reset is applied before any strobe. The stimulus drives only one operation per cycle, except in the cases that deliberately collide a forced trigger with a comparator match or two comparators on one address. It keeps execute slots within the four-entry queue.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
   typedef enum logic [2:0] {
      ST_DISARMED = 3'd0,
      ST_ONE      = 3'd1,
      ST_TWO      = 3'd2,
      ST_THREE    = 3'd3,
      ST_FINAL    = 3'd4
   } seq_state_e;

   localparam int CTL_ARM   = 0;
   localparam int CTL_TRIG  = 1;
   localparam int CTL_TRACE = 2;
   localparam int CTL_BRK   = 3;
   localparam int NUM_ARMED = 3;
endpackage

// File: rtl/dbg_addr_cmp.sv
module dbg_addr_cmp #(
   parameter int ADDR_W = 16,
   parameter int NCMP   = 2
) (
   input  logic [ADDR_W-1:0]            addr,
   input  logic                         valid,
   input  logic [NCMP-1:0][ADDR_W-1:0]  ref_addr,
   input  logic [NCMP-1:0]              en,
   output logic [NCMP-1:0]              match
);
   for (genvar g = 0; g < NCMP; g++) begin : g_cmp
      assign match[g] = valid && en[g] && (addr == ref_addr[g]);
   end
endmodule

// File: rtl/dbg_tag_q.sv
module dbg_tag_q #(
   parameter int NCMP   = 2,
   parameter int DEPTH  = 4,
   parameter int SLOT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [NCMP-1:0]   tag_in,
   input  logic              exec_v,
   input  logic [SLOT_W-1:0] exec_slot,
   input  logic              flush,
   output logic [NCMP-1:0]   hit
);
   logic [DEPTH-1:0][NCMP-1:0] q, qn;

   assign hit = exec_v ? q[exec_slot] : '0;

   always_comb begin
      qn = q;
      if (exec_v) qn[exec_slot] = '0;
      if (push) begin
         for (int i = DEPTH-1; i > 0; i--) qn[i] = qn[i-1];
         qn[0] = tag_in;
      end
      if (flush) qn = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= qn;
   end

   // R5: nothing survives a flush, so the next execute sees no tag
   a_r5_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (hit == '0));
endmodule

// File: rtl/dbg_seq_fsm.sv
module dbg_seq_fsm
   import dbg_seq_pkg::*;
#(
   parameter int NCMP = 2
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 ctl_wr,
   input  logic [3:0]                           ctl_bits,
   input  logic                                 force_in,
   input  logic [NCMP-1:0]                      ev,
   input  logic [NUM_ARMED-1:0][NCMP-1:0][2:0]  nxt_tbl,
   output seq_state_e                           state,
   output logic                                 trace_start,
   output logic                                 brk
);
   seq_state_e ns;
   logic       tr_en, bk_en, tr_en_n, bk_en_n;
   logic       armed, ev_any;
   logic [2:0] dest;

   assign armed   = (state == ST_ONE) || (state == ST_TWO) || (state == ST_THREE);
   assign tr_en_n = ctl_wr ? ctl_bits[CTL_TRACE] : tr_en;
   assign bk_en_n = ctl_wr ? ctl_bits[CTL_BRK]   : bk_en;

   always_comb begin
      dest   = 3'd0;
      ev_any = 1'b0;
      for (int c = NCMP-1; c >= 0; c--) begin
         if (ev[c]) begin
            ev_any = 1'b1;
            case (state)
               ST_ONE:   dest = nxt_tbl[0][c];
               ST_TWO:   dest = nxt_tbl[1][c];
               ST_THREE: dest = nxt_tbl[2][c];
               default:  dest = 3'd0;
            endcase
         end
      end
   end

   always_comb begin
      ns = state;
      if (armed) begin
         if (force_in)
            ns = ST_FINAL;
         else if (ev_any && dest >= 3'd1 && dest <= 3'd4)
            ns = seq_state_e'(dest);
      end
      if (ctl_wr) begin
         if (!ctl_bits[CTL_ARM])        ns = ST_DISARMED;
         else if (ctl_bits[CTL_TRIG])   ns = ST_FINAL;
         else if (state == ST_DISARMED) ns = ST_ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_DISARMED;
         tr_en       <= 1'b0;
         bk_en       <= 1'b0;
         trace_start <= 1'b0;
         brk         <= 1'b0;
      end else begin
         state       <= ns;
         tr_en       <= tr_en_n;
         bk_en       <= bk_en_n;
         trace_start <= (ns == ST_FINAL) && (state != ST_FINAL) && tr_en_n;
         brk         <= (ns == ST_FINAL) && (state != ST_FINAL) && bk_en_n;
      end
   end

   a_r2_disarm: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !ctl_bits[CTL_ARM]) |=> (state == ST_DISARMED));
   a_r7_force_final: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && force_in && !ctl_wr) |=> (state == ST_FINAL));
   a_r9_brk_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      brk |=> !brk);
   a_r9_trace_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      trace_start |-> (state == ST_FINAL && $past(state) != ST_FINAL));
   a_r10_final_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FINAL && !ctl_wr) |=> (state == ST_FINAL));
   a_r1_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
      (state <= ST_FINAL));
endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
   import dbg_seq_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int NCMP      = 2,
   parameter int TAG_DEPTH = 4,
   parameter int SLOT_W    = $clog2(TAG_DEPTH),
   parameter int ADR_W     = 4,
   parameter int DATA_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_valid,
   input  logic              exec_valid,
   input  logic [SLOT_W-1:0] exec_slot,
   input  logic              pipe_flush,
   input  logic              ext_tag_hi,
   input  logic              ext_tag_lo,
   input  logic              sw_brk_req,
   input  logic              cfg_we,
   input  logic [ADR_W-1:0]  cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [2:0]        state,
   output logic              trace_start,
   output logic              brk
);
   localparam int CTL_A  = 0;
   localparam int CMP_A0 = 1;
   localparam int MODE_A = CMP_A0 + NCMP;
   localparam int NXT_A0 = MODE_A + 1;
   localparam int LAST_A = NXT_A0 + NUM_ARMED - 1;

   if (LAST_A >= (1 << ADR_W)) begin : g_chk_adr
      $error("ADR_W too small for register map");
   end
   if (DATA_W < ADDR_W || DATA_W < 3*NCMP || DATA_W < 2*NCMP || DATA_W < 4) begin : g_chk_dw
      $error("DATA_W too narrow");
   end
   if (TAG_DEPTH != (1 << SLOT_W) || TAG_DEPTH < 2) begin : g_chk_depth
      $error("TAG_DEPTH must be a power of two matching SLOT_W");
   end

   logic [NCMP-1:0][ADDR_W-1:0]                cmp_addr;
   logic [NCMP-1:0]                            tag_mode, cmp_en;
   logic [NUM_ARMED-1:0][NCMP-1:0][2:0]        nxt_tbl;
   logic [NCMP-1:0]                            match, tag_hit, ev;
   logic                                       ctl_wr, force_in;
   seq_state_e                                 st;

   assign ctl_wr   = cfg_we && (cfg_addr == ADR_W'(CTL_A));
   assign force_in = ext_tag_hi || ext_tag_lo || sw_brk_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_addr <= '0;
         tag_mode <= '0;
         cmp_en   <= '0;
         nxt_tbl  <= '0;
      end else if (cfg_we) begin
         for (int c = 0; c < NCMP; c++)
            if (cfg_addr == ADR_W'(CMP_A0 + c)) cmp_addr[c] <= cfg_wdata[ADDR_W-1:0];
         if (cfg_addr == ADR_W'(MODE_A)) begin
            tag_mode <= cfg_wdata[NCMP-1:0];
            cmp_en   <= cfg_wdata[2*NCMP-1:NCMP];
         end
         for (int s = 0; s < NUM_ARMED; s++)
            if (cfg_addr == ADR_W'(NXT_A0 + s)) nxt_tbl[s] <= cfg_wdata[3*NCMP-1:0];
      end
   end

   dbg_addr_cmp #(.ADDR_W(ADDR_W), .NCMP(NCMP)) u_cmp (
      .addr(fetch_addr), .valid(fetch_valid), .ref_addr(cmp_addr),
      .en(cmp_en), .match(match)
   );

   dbg_tag_q #(.NCMP(NCMP), .DEPTH(TAG_DEPTH), .SLOT_W(SLOT_W)) u_tagq (
      .clk(clk), .rst_n(rst_n), .push(fetch_valid), .tag_in(match & tag_mode),
      .exec_v(exec_valid), .exec_slot(exec_slot), .flush(pipe_flush), .hit(tag_hit)
   );

   assign ev = (match & ~tag_mode) | tag_hit;

   dbg_seq_fsm #(.NCMP(NCMP)) u_fsm (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_bits(cfg_wdata[3:0]),
      .force_in(force_in), .ev(ev), .nxt_tbl(nxt_tbl), .state(st),
      .trace_start(trace_start), .brk(brk)
   );

   assign state = st;

   // R4: a tag-mode match alone never moves the state
   a_r4_tag_defers: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && (match & tag_mode) != '0 && (match & ~tag_mode) == '0
       && !exec_valid && !force_in && !cfg_we) |=> $stable(state));
endmodule

// File: tb/sim_dbg_trig_seq.sv
module sim_dbg_trig_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] fetch_addr = '0;
   logic        fetch_valid = 0, exec_valid = 0, pipe_flush = 0;
   logic [1:0]  exec_slot = '0;
   logic        ext_tag_hi = 0, ext_tag_lo = 0, sw_brk_req = 0, cfg_we = 0;
   logic [3:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic [2:0]  state;
   logic        trace_start, brk;

   typedef struct { logic [2:0] st; logic tr; logic bk; string tag; } exp_t;
   exp_t sb[$];
   int   errors = 0, checks = 0;
   bit   done = 0;

   always #5 clk = ~clk;

   dbg_trig_seq u0 (
      .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .fetch_valid(fetch_valid),
      .exec_valid(exec_valid), .exec_slot(exec_slot), .pipe_flush(pipe_flush),
      .ext_tag_hi(ext_tag_hi), .ext_tag_lo(ext_tag_lo), .sw_brk_req(sw_brk_req),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .state(state), .trace_start(trace_start), .brk(brk)
   );

   // monitor: compares after each edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (state !== e.st || trace_start !== e.tr || brk !== e.bk) begin
               errors++;
               $display("FAIL %s: state/trace/brk = %0d/%0b/%0b expected %0d/%0b/%0b",
                        e.tag, state, trace_start, brk, e.st, e.tr, e.bk);
            end
         end
      end
   end

   task automatic step(input logic fv, input logic [15:0] fa, input logic ev,
                       input logic [1:0] es, input logic fl, input logic thi,
                       input logic tlo, input logic swb, input logic we,
                       input logic [3:0] wa, input logic [15:0] wd,
                       input logic [2:0] st, input logic tr, input logic bk,
                       input string tag);
      exp_t e;
      @(negedge clk);
      fetch_valid = fv; fetch_addr = fa; exec_valid = ev; exec_slot = es;
      pipe_flush = fl; ext_tag_hi = thi; ext_tag_lo = tlo; sw_brk_req = swb;
      cfg_we = we; cfg_addr = wa; cfg_wdata = wd;
      e.st = st; e.tr = tr; e.bk = bk; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic idle(input logic [2:0] st, input string tag);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, st, 0, 0, tag);
   endtask
   task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic [2:0] st,
                     input logic tr, input logic bk, input string tag);
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, a, d, st, tr, bk, tag);
   endtask
   task automatic fetch(input logic [15:0] a, input logic [2:0] st,
                        input logic tr, input logic bk, input string tag);
      step(1, a, 0, 0, 0, 0, 0, 0, 0, 0, 0, st, tr, bk, tag);
   endtask
   task automatic execs(input logic [1:0] s, input logic [2:0] st, input string tag);
      step(0, 0, 1, s, 0, 0, 0, 0, 0, 0, 0, st, 0, 0, tag);
   endtask

   // watchdog
   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: run hung, actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (state !== 3'd0 || trace_start !== 1'b0 || brk !== 1'b0) begin
         errors++;
         $display("FAIL R1: reset outputs %0d/%0b/%0b expected 0/0/0", state, trace_start, brk);
      end
      rst_n = 1'b1;
      idle(0, "R1");
      // configuration: cmp0 = 0x100, cmp1 = 0x200, both enabled, direct
      wr(1, 16'h0100, 0, 0, 0, "R2 cfg");
      wr(2, 16'h0200, 0, 0, 0, "R2 cfg");
      wr(3, 16'h000C, 0, 0, 0, "R2 cfg");
      wr(4, 16'd26, 0, 0, 0, "R3 cfg");   // S1: c0->2, c1->3
      wr(5, 16'd4,  0, 0, 0, "R6 cfg");   // S2: c0->4, c1->none
      wr(6, 16'd33, 0, 0, 0, "R3 cfg");   // S3: c0->1, c1->4
      step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R7 ignored when disarmed");
      fetch(16'h0100, 0, 0, 0, "R3 no match effect disarmed");
      wr(0, 16'h0001, 1, 0, 0, "R2 arm");
      fetch(16'h0150, 1, 0, 0, "R3 miss");
      fetch(16'h0100, 2, 0, 0, "R3 direct c0");
      fetch(16'h0200, 2, 0, 0, "R6 zero field no move");
      fetch(16'h0100, 4, 0, 0, "R9 final, pulses disabled");
      step(1, 16'h0100, 0, 0, 0, 1, 0, 0, 0, 0, 0, 4, 0, 0, "R10 sticky");
      wr(0, 16'h0000, 0, 0, 0, "R2 disarm from final");
      wr(0, 16'h000D, 1, 0, 0, "R2 arm with enables");
      idle(1, "R2 hold");
      fetch(16'h0200, 3, 0, 0, "R3 direct c1");
      fetch(16'h0200, 4, 1, 1, "R9 entry pulses");
      idle(4, "R9 one cycle");
      wr(0, 16'h000C, 0, 0, 0, "R2 disarm");
      wr(0, 16'h000D, 1, 0, 0, "R2 rearm");
      wr(2, 16'h0100, 1, 0, 0, "R6 cfg overlap");
      fetch(16'h0100, 2, 0, 0, "R6 lowest comparator wins");
      wr(2, 16'h0200, 2, 0, 0, "R6 restore");
      wr(0, 16'h000C, 0, 0, 0, "R2 disarm");
      wr(0, 16'h000D, 1, 0, 0, "R2 rearm");
      step(1, 16'h0100, 0, 0, 0, 0, 1, 0, 0, 0, 0, 4, 1, 1, "R7 force beats comparator");
      idle(4, "R9 one cycle");
      // tag mode on comparator 0
      wr(0, 16'h0000, 0, 0, 0, "R2 disarm");
      wr(3, 16'h000D, 0, 0, 0, "R4 cfg tag mode");
      wr(0, 16'h0001, 1, 0, 0, "R2 arm");
      fetch(16'h0100, 1, 0, 0, "R4 tag deferred");
      fetch(16'h0150, 1, 0, 0, "R4 tag shifts");
      execs(0, 1, "R4 untagged slot");
      execs(1, 2, "R4 tag hit");
      execs(1, 2, "R4 tag consumed");
      fetch(16'h0100, 2, 0, 0, "R4 tag deferred s2");
      step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 2, 0, 0, "R5 flush");
      execs(0, 2, "R5 no hit after flush");
      fetch(16'h0100, 2, 0, 0, "R4 retag");
      execs(0, 4, "R4 tag hit to final");
      // trigger bit
      wr(0, 16'h0000, 0, 0, 0, "R2 disarm");
      wr(0, 16'h000B, 4, 0, 1, "R8 trigger");
      idle(4, "R9 one cycle");
      wr(0, 16'h0000, 0, 0, 0, "R2 disarm");
      wr(0, 16'h000A, 0, 0, 0, "R8 trigger ignored without arm");
      wr(0, 16'h0001, 1, 0, 0, "R2 arm");
      step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 4, 0, 0, "R7 software request");
      wr(0, 16'h0000, 0, 0, 0, "R2 disarm");
      wr(0, 16'h0001, 1, 0, 0, "R2 arm");
      step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 4, 0, 0, "R7 ext tag hi");
      // invalid destination field
      wr(0, 16'h0000, 0, 0, 0, "R2 disarm");
      wr(3, 16'h000C, 0, 0, 0, "R6 cfg direct");
      wr(4, 16'd58, 0, 0, 0, "R6 cfg field 7");
      wr(0, 16'h0001, 1, 0, 0, "R2 arm");
      fetch(16'h0200, 1, 0, 0, "R6 field 7 no move");
      fetch(16'h0100, 2, 0, 0, "R3 c0 still works");
      idle(2, "R3 hold");
      repeat (3) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule